// File: doc/BRIEF.md
# Secure/Non-Secure Transaction Filter

This block sits in the memory path between a requester and a memory. The protected range is split into fixed-size blocks. Each block has one ownership bit in an external lookup table, and that bit says whether only secure or only non-secure transactions may reach the block. For every accepted request the filter reads the table word that holds the block's bit. In the next cycle it decides whether to forward the request to memory unchanged or to stop it.

A stopped request never reaches memory. A stopped read returns zero data. A stopped write changes nothing downstream. The reply reports an error only when the error-response control input is high; otherwise the access completes silently. The first stopped access after the status is clear records the full address, the requester ID, the effective security attribute and the block's table bit, then raises a sticky status. That record is held until the status is cleared. Software-visible registers and the table storage live outside this block: the filter drives a synchronous table read port and takes its controls as plain inputs.

Top module: `sec_txn_filter`

## Requirements
- R1: On the cycle a request is accepted, `tblRdIdx` equals (address >> BLK_LOG2) >> 5. The bit used within the returned word is (address >> BLK_LOG2) modulo 32.
- R2: When the table bit is 1, only non-secure requests pass. When the table bit is 0, only secure requests pass.
- R3: A request with `reqAttrKnown` low is treated as secure, whatever `reqNonSec` carries.
- R4: A passing request appears on the downstream side with the same address, direction and write data. `dnValid` is held with stable payload until `dnReady`. The downstream response data and error are relayed unchanged on `rspValid`.
- R5: A stopped request never raises `dnValid`. Its response comes in the cycle after acceptance with `rspData` equal to zero.
- R6: The error flag of a stopped request's response equals `cfgErrResp`.
- R7: When `irqStatus` is clear and a request is stopped, the block loads `infoAddr` with the full address. It loads `infoAttr` with the requester ID in bits 15:0, the effective non-secure flag in bit 16 and the block's table bit in bit 17. `irqStatus` is set on the same edge.
- R8: While `irqStatus` stays set, further stopped requests are still stopped but leave `infoAddr` and `infoAttr` unchanged.
- R9: A cycle with `irqClear` high clears `irqStatus`. If a stop happens in that same cycle, the clear takes effect first: the new violation is captured and `irqStatus` stays set.
- R10: `irq` is high exactly when `irqStatus` and `irqEnable` are both high.
- R11: After reset, `irqStatus`, `irq`, `infoAddr` and `infoAttr` are zero, `reqReady` is high and `dnValid` is low. With an all-zero table, every block is secure-only.
- R12: No accepted request carries an address at or beyond NUM_BLK << BLK_LOG2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request valid |
| reqReady | output | 1 | Filter ready to accept a request |
| reqAddr | input | ADDR_W | Request byte address |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | DATA_W | Write data |
| reqNonSec | input | 1 | Request is non-secure |
| reqAttrKnown | input | 1 | Security attribute is specified |
| reqMaster | input | 16 | Requester ID |
| rspValid | output | 1 | Response valid (one cycle) |
| rspData | output | DATA_W | Read data |
| rspErr | output | 1 | Error response |
| dnValid | output | 1 | Downstream request valid |
| dnReady | input | 1 | Downstream accepts request |
| dnAddr | output | ADDR_W | Downstream address |
| dnWrite | output | 1 | Downstream direction |
| dnWdata | output | DATA_W | Downstream write data |
| dnRspValid | input | 1 | Downstream response valid |
| dnRspData | input | DATA_W | Downstream read data |
| dnRspErr | input | 1 | Downstream error |
| tblRdEn | output | 1 | Table read strobe |
| tblRdIdx | output | IDX_W | Table word index |
| tblRdWord | input | 32 | Table word, registered, valid the cycle after tblRdEn |
| cfgErrResp | input | 1 | Stopped accesses report an error |
| irqEnable | input | 1 | Interrupt enable |
| irqClear | input | 1 | Clear violation status |
| irq | output | 1 | Interrupt |
| irqStatus | output | 1 | Sticky violation status |
| infoAddr | output | ADDR_W | Captured violation address |
| infoAttr | output | 18 | Captured ID / non-secure flag / table bit |

## Verification
The capture of a new violation and a software clear of the status can land on the same clock edge. The bench provokes this by pulsing `irqClear` in the decision cycle of a request that is certain to be stopped, while an older violation is still recorded. It then judges the result one cycle later: the newer address and attributes must replace the old record and the status must remain set. The same clear pulse is also placed on passing requests, where it must simply drop the status.

// File: rtl/sfilt_pkg.sv
package sfilt_pkg;

  localparam int MID_W   = 16;
  localparam int ATTR_W  = 18;
  localparam int NS_POS  = 16;
  localparam int CFG_POS = 17;
  localparam int LUT_W   = 32;
  localparam int SEL_W   = 5;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOOK = 2'd1,
    ST_FWD  = 2'd2,
    ST_WAIT = 2'd3
  } fsmState_t;

  typedef struct packed {
    logic loadReq;
    logic blockEvt;
    logic relayRsp;
  } strobe_t;

endpackage

// File: rtl/sfilt_ctrl.sv
module sfilt_ctrl
  import sfilt_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    passOk,
  input  logic    dnReady,
  input  logic    dnRspValid,
  output logic    reqReady,
  output logic    dnValid,
  output logic    tblRdEn,
  output logic    rspValid,
  output strobe_t strb
);

  fsmState_t curState;
  fsmState_t nxtState;
  logic      accept;

  assign accept   = reqValid && (curState == ST_IDLE);
  assign reqReady = (curState == ST_IDLE);
  assign tblRdEn  = accept;
  assign dnValid  = (curState == ST_FWD);

  always_comb begin
    strb          = '0;
    strb.loadReq  = accept;
    strb.blockEvt = (curState == ST_LOOK) && !passOk;
    strb.relayRsp = (curState == ST_WAIT) && dnRspValid;
  end

  assign rspValid = strb.blockEvt || strb.relayRsp;

  always_comb begin
    nxtState = curState;
    unique case (curState)
      ST_IDLE: if (accept) nxtState = ST_LOOK;
      ST_LOOK: nxtState = passOk ? ST_FWD : ST_IDLE;
      ST_FWD:  if (dnReady) nxtState = ST_WAIT;
      ST_WAIT: if (dnRspValid) nxtState = ST_IDLE;
      default: nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) curState <= ST_IDLE;
    else       curState <= nxtState;
  end

endmodule

// File: rtl/sfilt_datapath.sv
module sfilt_datapath
  import sfilt_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int BLK_LOG2 = 8,
  parameter int IDX_W    = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqNonSec,
  input  logic              reqAttrKnown,
  input  logic [MID_W-1:0]  reqMaster,
  input  logic [LUT_W-1:0]  tblRdWord,
  input  logic              cfgErrResp,
  input  logic              irqClear,
  input  logic [DATA_W-1:0] dnRspData,
  input  logic              dnRspErr,
  output logic              passOk,
  output logic [IDX_W-1:0]  tblRdIdx,
  output logic [ADDR_W-1:0] dnAddr,
  output logic              dnWrite,
  output logic [DATA_W-1:0] dnWdata,
  output logic [DATA_W-1:0] rspData,
  output logic              rspErr,
  output logic              irqStatus,
  output logic [ADDR_W-1:0] infoAddr,
  output logic [ATTR_W-1:0] infoAttr
);

  localparam int BLK_W = ADDR_W - BLK_LOG2;

  logic [BLK_W-1:0]  reqBlk;
  logic [ADDR_W-1:0] heldAddr;
  logic              heldWrite;
  logic [DATA_W-1:0] heldWdata;
  logic              heldNs;
  logic [MID_W-1:0]  heldMaster;
  logic [SEL_W-1:0]  bitSel;
  logic              tblBit;
  logic              statusFree;

  // word index of the target block
  assign reqBlk   = reqAddr[ADDR_W-1:BLK_LOG2];
  assign tblRdIdx = IDX_W'(reqBlk >> SEL_W);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      heldAddr   <= '0;
      heldWrite  <= 1'b0;
      heldWdata  <= '0;
      heldNs     <= 1'b0;
      heldMaster <= '0;
    end else if (strb.loadReq) begin
      heldAddr   <= reqAddr;
      heldWrite  <= reqWrite;
      heldWdata  <= reqWdata;
      heldNs     <= reqNonSec && reqAttrKnown;
      heldMaster <= reqMaster;
    end
  end

  // bit of the block within the returned word
  assign bitSel = heldAddr[BLK_LOG2 +: SEL_W];
  assign tblBit = tblRdWord[bitSel];
  assign passOk = (tblBit == heldNs);

  assign dnAddr  = heldAddr;
  assign dnWrite = heldWrite;
  assign dnWdata = heldWdata;

  assign rspData = strb.blockEvt ? '0 : dnRspData;
  assign rspErr  = strb.blockEvt ? cfgErrResp : dnRspErr;

  // clear is applied before a coincident capture
  assign statusFree = !irqStatus || irqClear;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqStatus <= 1'b0;
      infoAddr  <= '0;
      infoAttr  <= '0;
    end else if (strb.blockEvt && statusFree) begin
      irqStatus         <= 1'b1;
      infoAddr          <= heldAddr;
      infoAttr          <= '0;
      infoAttr[MID_W-1:0] <= heldMaster;
      infoAttr[NS_POS]  <= heldNs;
      infoAttr[CFG_POS] <= tblBit;
    end else if (irqClear) begin
      irqStatus <= 1'b0;
    end
  end

endmodule

// File: rtl/sec_txn_filter.sv
module sec_txn_filter
  import sfilt_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int BLK_LOG2 = 8,
  parameter int NUM_BLK  = 64,
  localparam int WORDS   = (NUM_BLK + LUT_W - 1) / LUT_W,
  localparam int IDX_W   = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqNonSec,
  input  logic              reqAttrKnown,
  input  logic [15:0]       reqMaster,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspErr,
  output logic              dnValid,
  input  logic              dnReady,
  output logic [ADDR_W-1:0] dnAddr,
  output logic              dnWrite,
  output logic [DATA_W-1:0] dnWdata,
  input  logic              dnRspValid,
  input  logic [DATA_W-1:0] dnRspData,
  input  logic              dnRspErr,
  output logic              tblRdEn,
  output logic [IDX_W-1:0]  tblRdIdx,
  input  logic [31:0]       tblRdWord,
  input  logic              cfgErrResp,
  input  logic              irqEnable,
  input  logic              irqClear,
  output logic              irq,
  output logic              irqStatus,
  output logic [ADDR_W-1:0] infoAddr,
  output logic [17:0]       infoAttr
);

  strobe_t strb;
  logic    passOk;

  sfilt_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .passOk     (passOk),
    .dnReady    (dnReady),
    .dnRspValid (dnRspValid),
    .reqReady   (reqReady),
    .dnValid    (dnValid),
    .tblRdEn    (tblRdEn),
    .rspValid   (rspValid),
    .strb       (strb)
  );

  sfilt_datapath #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .BLK_LOG2 (BLK_LOG2),
    .IDX_W    (IDX_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .reqAddr      (reqAddr),
    .reqWrite     (reqWrite),
    .reqWdata     (reqWdata),
    .reqNonSec    (reqNonSec),
    .reqAttrKnown (reqAttrKnown),
    .reqMaster    (reqMaster),
    .tblRdWord    (tblRdWord),
    .cfgErrResp   (cfgErrResp),
    .irqClear     (irqClear),
    .dnRspData    (dnRspData),
    .dnRspErr     (dnRspErr),
    .passOk       (passOk),
    .tblRdIdx     (tblRdIdx),
    .dnAddr       (dnAddr),
    .dnWrite      (dnWrite),
    .dnWdata      (dnWdata),
    .rspData      (rspData),
    .rspErr       (rspErr),
    .irqStatus    (irqStatus),
    .infoAddr     (infoAddr),
    .infoAttr     (infoAttr)
  );

  assign irq = irqStatus && irqEnable;

endmodule

// File: rtl/sec_txn_filter_chk.sv
module sec_txn_filter_chk #(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 32,
  parameter int BLK_LOG2 = 8,
  parameter int NUM_BLK  = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspData,
  input logic              rspErr,
  input logic              dnValid,
  input logic              dnReady,
  input logic [ADDR_W-1:0] dnAddr,
  input logic              dnWrite,
  input logic [DATA_W-1:0] dnWdata,
  input logic              dnRspValid,
  input logic              tblRdEn,
  input logic              cfgErrResp,
  input logic              irqClear,
  input logic              irqStatus,
  input logic [ADDR_W-1:0] infoAddr,
  input logic [17:0]       infoAttr
);

  localparam logic [ADDR_W:0] RANGE_LIM = (ADDR_W+1)'(NUM_BLK) << BLK_LOG2;

  logic stopRsp;
  assign stopRsp = rspValid && !dnRspValid;

  assert_lookup_first_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dnValid) |-> $past(tblRdEn, 2));

  assert_fwd_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    dnValid && !dnReady |=> dnValid && $stable(dnAddr) && $stable(dnWrite) && $stable(dnWdata));

  assert_stop_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    stopRsp |-> (rspData == '0) && !dnValid);

  assert_stop_err_R6: assert property (@(posedge clk) disable iff (!rstN)
    stopRsp |-> (rspErr == cfgErrResp));

  assert_status_src_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqStatus) |-> $past(stopRsp));

  assert_info_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    $past(irqStatus) && !$past(irqClear) |-> irqStatus && $stable(infoAddr) && $stable(infoAttr));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    $past(irqClear) && !$past(stopRsp) |-> !irqStatus);

  assert_in_range_R12: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |-> ({1'b0, reqAddr} < RANGE_LIM));

endmodule

bind sec_txn_filter sec_txn_filter_chk #(
  .ADDR_W   (ADDR_W),
  .DATA_W   (DATA_W),
  .BLK_LOG2 (BLK_LOG2),
  .NUM_BLK  (NUM_BLK)
) u_chk (.*);

// File: tb/sec_txn_filter_bench.sv
module sec_txn_filter_bench;

  localparam int ADDR_W   = 16;
  localparam int DATA_W   = 32;
  localparam int BLK_LOG2 = 8;
  localparam int NUM_BLK  = 64;
  localparam int WORDS    = (NUM_BLK + 31) / 32;
  localparam int IDX_W    = (WORDS > 1) ? $clog2(WORDS) : 1;
  localparam int SPAN     = NUM_BLK << BLK_LOG2;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              reqValid = 1'b0;
  logic              reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic              reqWrite = 1'b0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic              reqNonSec = 1'b0;
  logic              reqAttrKnown = 1'b1;
  logic [15:0]       reqMaster = '0;
  logic              rspValid;
  logic [DATA_W-1:0] rspData;
  logic              rspErr;
  logic              dnValid;
  logic              dnReady = 1'b1;
  logic [ADDR_W-1:0] dnAddr;
  logic              dnWrite;
  logic [DATA_W-1:0] dnWdata;
  logic              dnRspValid;
  logic [DATA_W-1:0] dnRspData;
  logic              dnRspErr;
  logic              tblRdEn;
  logic [IDX_W-1:0]  tblRdIdx;
  logic [31:0]       tblRdWord = '0;
  logic              cfgErrResp = 1'b0;
  logic              irqEnable = 1'b1;
  logic              irqClear = 1'b0;
  logic              irq;
  logic              irqStatus;
  logic [ADDR_W-1:0] infoAddr;
  logic [17:0]       infoAttr;

  sec_txn_filter #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .BLK_LOG2 (BLK_LOG2), .NUM_BLK (NUM_BLK)
  ) u_sec_txn_filter (
    .clk (clk), .rstN (rstN),
    .reqValid (reqValid), .reqReady (reqReady), .reqAddr (reqAddr),
    .reqWrite (reqWrite), .reqWdata (reqWdata), .reqNonSec (reqNonSec),
    .reqAttrKnown (reqAttrKnown), .reqMaster (reqMaster),
    .rspValid (rspValid), .rspData (rspData), .rspErr (rspErr),
    .dnValid (dnValid), .dnReady (dnReady), .dnAddr (dnAddr),
    .dnWrite (dnWrite), .dnWdata (dnWdata),
    .dnRspValid (dnRspValid), .dnRspData (dnRspData), .dnRspErr (dnRspErr),
    .tblRdEn (tblRdEn), .tblRdIdx (tblRdIdx), .tblRdWord (tblRdWord),
    .cfgErrResp (cfgErrResp), .irqEnable (irqEnable), .irqClear (irqClear),
    .irq (irq), .irqStatus (irqStatus), .infoAddr (infoAddr), .infoAttr (infoAttr)
  );

  always #10 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;
  int cycles  = 0;

  // ownership table model, zero after reset
  logic [31:0] tbl [WORDS];

  always @(posedge clk) if (tblRdEn) tblRdWord <= tbl[tblRdIdx];

  // downstream memory model
  logic [ADDR_W-1:0] lastDnAddr = '0;
  logic              lastDnWrite = 1'b0;
  logic [DATA_W-1:0] lastDnWdata = '0;
  int                dnCount = 0;
  logic [1:0]        rspTimer = '0;
  logic [ADDR_W-1:0] rspAddr = '0;
  logic              rspWr = 1'b0;

  function automatic logic [DATA_W-1:0] memFn(input logic [ADDR_W-1:0] a);
    return {a ^ 16'h5A3C, ~a};
  endfunction

  function automatic logic errFn(input logic [ADDR_W-1:0] a);
    return a[3:0] == 4'hC;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      rspTimer <= '0;
    end else if (dnValid && dnReady) begin
      lastDnAddr  <= dnAddr;
      lastDnWrite <= dnWrite;
      lastDnWdata <= dnWdata;
      dnCount     <= dnCount + 1;
      rspTimer    <= 2'd3;
      rspAddr     <= dnAddr;
      rspWr       <= dnWrite;
    end else if (rspTimer != 0) begin
      rspTimer <= rspTimer - 1;
    end
  end

  assign dnRspValid = (rspTimer == 2'd1);
  assign dnRspData  = (dnRspValid && !rspWr) ? memFn(rspAddr) : '0;
  assign dnRspErr   = dnRspValid && errFn(rspAddr);

  always @(negedge clk) dnReady = ($urandom % 4) != 0;

  // expected violation record
  logic              expStatus = 1'b0;
  logic [ADDR_W-1:0] expInfoAddr = '0;
  logic [17:0]       expInfoAttr = '0;

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finishRun();
    end
  end

  task automatic checkRecord(input string req);
    check(irqStatus == expStatus, req, 64'(irqStatus), 64'(expStatus));
    check(infoAddr == expInfoAddr, req, 64'(infoAddr), 64'(expInfoAddr));
    check(infoAttr == expInfoAttr, req, 64'(infoAttr), 64'(expInfoAttr));
    check(irq == (expStatus && irqEnable), "R10", 64'(irq), 64'(expStatus && irqEnable));
  endtask

  task automatic doTxn(input logic [ADDR_W-1:0] a, input logic w, input logic [DATA_W-1:0] wd,
                       input logic ns, input logic known, input logic [15:0] mid, input logic clr);
    int blk;
    int word;
    int bitN;
    logic tb;
    logic effNs;
    logic pass;
    int dnBefore;
    int lat;
    logic [DATA_W-1:0] gotData;
    logic gotErr;
    string passTag;
    blk   = int'(a) >> BLK_LOG2;
    word  = blk >> 5;
    bitN  = blk % 32;
    tb    = tbl[word][bitN];
    effNs = ns && known;
    pass  = (tb == effNs);
    passTag = known ? "R2" : "R3";
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqAddr = a; reqWrite = w; reqWdata = wd; reqNonSec = ns;
    reqAttrKnown = known; reqMaster = mid; reqValid = 1'b1;
    dnBefore = dnCount;
    #1;
    check(tblRdIdx == IDX_W'(word), "R1", 64'(tblRdIdx), 64'(word));
    @(negedge clk);
    reqValid = 1'b0;
    irqClear = clr;
    lat = 1;
    while (!rspValid && lat < 60) begin
      @(negedge clk);
      irqClear = 1'b0;
      lat++;
    end
    gotData = rspData;
    gotErr  = rspErr;
    if (pass) begin
      check(dnCount == dnBefore + 1, passTag, 64'(dnCount - dnBefore), 64'd1);
      check(lastDnAddr == a, "R4", 64'(lastDnAddr), 64'(a));
      check(lastDnWrite == w, "R4", 64'(lastDnWrite), 64'(w));
      if (w) check(lastDnWdata == wd, "R4", 64'(lastDnWdata), 64'(wd));
      check(gotData == (w ? '0 : memFn(a)), "R4", 64'(gotData), 64'(w ? '0 : memFn(a)));
      check(gotErr == errFn(a), "R4", 64'(gotErr), 64'(errFn(a)));
    end else begin
      check(dnCount == dnBefore, passTag, 64'(dnCount - dnBefore), 64'd0);
      check(lat == 1, "R5", 64'(lat), 64'd1);
      check(gotData == '0, "R5", 64'(gotData), 64'd0);
      check(gotErr == cfgErrResp, "R6", 64'(gotErr), 64'(cfgErrResp));
    end
    @(negedge clk);
    irqClear = 1'b0;
    if (clr) expStatus = 1'b0;
    if (!pass && !expStatus) begin
      expStatus   = 1'b1;
      expInfoAddr = a;
      expInfoAttr = {tb, effNs, mid};
    end
    checkRecord(clr ? "R9" : (pass ? "R8" : "R7"));
  endtask

  task automatic pulseClear();
    @(negedge clk);
    irqClear = 1'b1;
    @(negedge clk);
    irqClear = 1'b0;
    expStatus = 1'b0;
    checkRecord("R9");
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < WORDS; i++) tbl[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R11: reset state
    check(irqStatus == 1'b0, "R11", 64'(irqStatus), 64'd0);
    check(irq == 1'b0, "R11", 64'(irq), 64'd0);
    check(infoAddr == '0, "R11", 64'(infoAddr), 64'd0);
    check(infoAttr == '0, "R11", 64'(infoAttr), 64'd0);
    check(reqReady == 1'b1, "R11", 64'(reqReady), 64'd1);
    check(dnValid == 1'b0, "R11", 64'(dnValid), 64'd0);

    // R11/R2: zeroed table lets secure through, stops non-secure
    doTxn(16'h0140, 1'b0, '0, 1'b0, 1'b1, 16'h0011, 1'b0);
    doTxn(16'h0244, 1'b0, '0, 1'b1, 1'b1, 16'hBEEF, 1'b0);   // R7 first capture
    cfgErrResp = 1'b1;
    doTxn(16'h0388, 1'b1, 32'hCAFE0001, 1'b1, 1'b1, 16'h1234, 1'b0); // R8 no overwrite, R6
    pulseClear();
    // R3: unspecified attribute behaves as secure
    doTxn(16'h0400, 1'b0, '0, 1'b1, 1'b0, 16'h0003, 1'b0);
    // R1: block 40 lives in word 1 bit 8
    tbl[1] = 32'h0000_0100;
    doTxn(16'h2810, 1'b0, '0, 1'b1, 1'b1, 16'h0040, 1'b0);
    doTxn(16'h2820, 1'b1, 32'h11223344, 1'b0, 1'b1, 16'h0041, 1'b0); // stopped, bit17 set
    doTxn(16'h2830, 1'b0, '0, 1'b1, 1'b0, 16'h0042, 1'b0);           // R3 stopped
    // R9: stop coincident with clear while a record is held
    doTxn(16'h3F04, 1'b0, '0, 1'b1, 1'b1, 16'h7777, 1'b1);
    doTxn(16'h0010, 1'b1, 32'hA5A5A5A5, 1'b0, 1'b1, 16'h0001, 1'b1); // clear on pass
    irqEnable = 1'b0;
    cfgErrResp = 1'b0;
    doTxn(16'h0500, 1'b0, '0, 1'b1, 1'b1, 16'h0099, 1'b0);           // R10 masked
    irqEnable = 1'b1;
    @(negedge clk);
    checkRecord("R10");

    // constrained random phase
    for (int n = 0; n < 400; n++) begin
      if (($urandom % 20) == 0) begin
        for (int i = 0; i < WORDS; i++) tbl[i] = $urandom;
      end
      if (($urandom % 10) == 0) pulseClear();
      cfgErrResp = $urandom % 2;
      irqEnable  = ($urandom % 4) != 0;
      doTxn(ADDR_W'($urandom % SPAN), 1'($urandom), $urandom, 1'($urandom),
            ($urandom % 5) != 0, 16'($urandom), ($urandom % 8) == 0);
    end
    finishRun();
  end

endmodule